// File: doc/BRIEF.md
# Page Write Load Controller

This block sits behind an asynchronous, SRAM-style write bus made of active-low chip select, write strobe and output enable lines plus a 15-bit address and an 8-bit data bus, all sampled in the local clock domain. It takes in byte writes and gathers them into a 64-byte page buffer. Once the gap after the latest byte exceeds a byte-load limit, it enters a programming period of fixed length. During that period it emits one commit strobe for each byte that was actually loaded. A behavioural memory array placed next to the block consumes these strobes.

The control flow is a state machine with five states. `PL_WAIT_PWR` holds off writes until the supply-good input has stayed high for the power-on delay. `PL_IDLE` waits for the first byte. `PL_LOAD` gathers bytes of the open page. `PL_PROGRAM` walks the 64 offsets and emits the commit strobes. `PL_SETTLE` holds busy until the programming period has run out.

The named transitions are:
- power-good: WAIT_PWR to IDLE.
- supply-lost: IDLE to WAIT_PWR.
- open: IDLE to LOAD, on the first byte.
- extend: LOAD to LOAD, on a byte of the same page.
- timeout: LOAD to PROGRAM, when the byte-load limit expires.
- walk-done: PROGRAM to SETTLE, after offset 63.
- release: SETTLE to IDLE, when the programming period expires; this also clears the loaded mask.

Top module: `page_load_ctrl`

## Requirements
- R1: A write needs a joint low phase of the chip select (`bus_ce_n`) and the write strobe (`bus_we_n`) that lasts at least GLITCH_CYC sampled clock cycles. A shorter joint low phase is ignored.
- R2: The address is the value present in the first cycle of the joint low phase, set by the later of the two falling edges. The data is the value present in its last cycle, set by the earlier of the two rising edges.
- R3: No write happens if `bus_oe_n` is low at any point of the joint low phase. No write happens if only one of `bus_ce_n` and `bus_we_n` goes low.
- R4: Address bits 14..6 select the page and bits 5..0 select the offset within it. The first accepted byte opens a load window. Each further byte of the same page restarts a byte-load limit of BLC_CYC cycles, so bytes spaced closer than that limit share one window.
- R5: When the byte-load limit expires with no new byte, programming starts. `busy` is then high for exactly TWC_CYC consecutive cycles.
- R6: While busy, the block emits exactly one `commit_valid` cycle per loaded offset, in ascending offset order. `commit_addr` is {page, offset} and `commit_data` is the byte loaded there. Unloaded offsets produce no strobe, and `commit_valid` never occurs outside busy.
- R7: Bytes may be loaded in any order. An offset written twice in one window commits once, with the later data.
- R8: A byte that targets a different page while a window is open is ignored and sets `page_err`. `page_err` clears when the next window opens.
- R9: Writes that complete while `busy` is high are ignored and do not open a window afterwards.
- R10: After reset, writes are ignored until `supply_ok` has been high for POR_CYC consecutive cycles. A drop of `supply_ok` while idle restarts that wait.
- R11: `last_addr` and `last_data` show the most recent accepted byte. After reset they are 0, and so are `busy`, `page_err` and `commit_valid`.
- R12: The loaded mask is empty when `busy` falls, so a later window commits only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply-good indication |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low; write inhibit when low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_addr | input | 15 | Byte address |
| bus_din | input | 8 | Write data |
| busy | output | 1 | Programming period in progress |
| page_err | output | 1 | A byte of a foreign page was dropped in the open window |
| last_addr | output | 15 | Address of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |
| commit_valid | output | 1 | Commit strobe for one loaded byte |
| commit_addr | output | 15 | Address of the committed byte |
| commit_data | output | 8 | Data of the committed byte |

## Verification
A corrupted loaded mask or page register appears within one programming walk, as a missing, extra or misaddressed `commit_valid` cycle. The scoreboard compares every such cycle against the bytes the bench chose to load. A wrong timer shows up as a programming period whose `busy` length differs from TWC_CYC. It can also show up as two bytes splitting into two windows, or as bytes accepted before the power-on wait is over. A broken qualifier becomes visible a few cycles after the bus pulse ends, in `last_addr` and `last_data`, when a glitch, an inhibited pulse or a byte sent during busy changes them.

// File: rtl/pl_pkg.sv
package pl_pkg;
    typedef enum logic [2:0] {
        PL_WAIT_PWR,
        PL_IDLE,
        PL_LOAD,
        PL_PROGRAM,
        PL_SETTLE
    } pl_state_e;
endpackage

// File: rtl/pl_bus_strobe.sv
// Samples the asynchronous bus and turns one qualified joint low phase
// of chip select and write strobe into a single-cycle write event.
module pl_bus_strobe #(
    parameter int AW         = 15,
    parameter int DW         = 8,
    parameter int GLITCH_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          ev,
    output logic [AW-1:0] ev_addr,
    output logic [DW-1:0] ev_data
);
    localparam int LW = $clog2(GLITCH_CYC + 1);
    localparam logic [LW-1:0] LEN_MIN = LW'(GLITCH_CYC);

    logic [1:0]    ce_p, we_p, oe_p;
    logic [AW-1:0] a1, a2;
    logic [DW-1:0] d1, d2;
    logic          act, act_q, inhibit;
    logic [LW-1:0] len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_p <= 2'b11;
            we_p <= 2'b11;
            oe_p <= 2'b11;
            a1   <= '0;
            a2   <= '0;
            d1   <= '0;
            d2   <= '0;
        end else begin
            ce_p <= {ce_p[0], ce_n};
            we_p <= {we_p[0], we_n};
            oe_p <= {oe_p[0], oe_n};
            a1   <= addr;
            a2   <= a1;
            d1   <= din;
            d2   <= d1;
        end
    end

    assign act = !ce_p[1] && !we_p[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            len     <= '0;
            inhibit <= 1'b0;
            ev      <= 1'b0;
            ev_addr <= '0;
            ev_data <= '0;
        end else begin
            act_q <= act;
            ev    <= 1'b0;
            if (act && !act_q) begin
                ev_addr <= a2;
                ev_data <= d2;
                len     <= LW'(1);
                inhibit <= !oe_p[1];
            end else if (act) begin
                ev_data <= d2;
                if (len < LEN_MIN) len <= len + LW'(1);
                inhibit <= inhibit || !oe_p[1];
            end else if (act_q) begin
                ev <= (len >= LEN_MIN) && !inhibit;
            end
        end
    end

    // R1: an event always follows directly on the end of a joint low phase
    assert_event_after_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev |-> ($past(act_q) && !$past(act)));
endmodule

// File: rtl/pl_cycle_timer.sv
// Cycle counter that reports once LIMIT cycles of run have been seen.
module pl_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (restart)        cnt <= '0;
        else if (run && !done)   cnt <= cnt + CW'(1);
    end

    assign done = (cnt >= LAST);
endmodule

// File: rtl/pl_page_buf.sv
// Page data latches with one loaded flag per offset.
module pl_page_buf #(
    parameter int DW    = 8,
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [DW-1:0]    wr_data,
    input  logic             clr,
    input  logic [OFF_W-1:0] rd_off,
    output logic [DW-1:0]    rd_data,
    output logic             rd_loaded,
    output logic [(1<<OFF_W)-1:0] mask
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DW-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[i] <= '0;
                mask[i] <= 1'b0;
            end else if (clr) begin
                mask[i] <= 1'b0;
            end else if (wr_en && wr_off == OFF_W'(i)) begin
                slot[i] <= wr_data;
                mask[i] <= 1'b1;
            end
        end
    end

    assign rd_data   = slot[rd_off];
    assign rd_loaded = mask[rd_off];
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int OFF_W      = 6,
    parameter int GLITCH_CYC = 2,
    parameter int BLC_CYC    = 15000,
    parameter int TWC_CYC    = 1000000,
    parameter int POR_CYC    = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic              busy,
    output logic              page_err,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data,
    output logic              commit_valid,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);
    import pl_pkg::*;

    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int DEPTH = 1 << OFF_W;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(DEPTH - 1);

    pl_state_e state, state_nx;

    logic              ev;
    logic [ADDR_W-1:0] ev_addr;
    logic [DATA_W-1:0] ev_data;
    logic [PG_W-1:0]   page_q;
    logic [OFF_W-1:0]  idx;
    logic              por_done, blc_done, twc_done;
    logic              acc_first, acc_more, reject, accept, clr;
    logic [DATA_W-1:0] rd_data;
    logic              rd_loaded;
    logic [DEPTH-1:0]  buf_mask;

    pl_bus_strobe #(.AW(ADDR_W), .DW(DATA_W), .GLITCH_CYC(GLITCH_CYC)) u_strobe (
        .clk(clk), .rst_n(rst_n),
        .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n),
        .addr(bus_addr), .din(bus_din),
        .ev(ev), .ev_addr(ev_addr), .ev_data(ev_data)
    );

    pl_cycle_timer #(.LIMIT(POR_CYC)) u_por (
        .clk(clk), .rst_n(rst_n),
        .restart(!supply_ok || state != PL_WAIT_PWR),
        .run(state == PL_WAIT_PWR),
        .done(por_done)
    );

    pl_cycle_timer #(.LIMIT(BLC_CYC)) u_blc (
        .clk(clk), .rst_n(rst_n),
        .restart(accept),
        .run(state == PL_LOAD),
        .done(blc_done)
    );

    pl_cycle_timer #(.LIMIT(TWC_CYC)) u_twc (
        .clk(clk), .rst_n(rst_n),
        .restart(state == PL_LOAD),
        .run(busy),
        .done(twc_done)
    );

    pl_page_buf #(.DW(DATA_W), .OFF_W(OFF_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_off(ev_addr[OFF_W-1:0]), .wr_data(ev_data),
        .clr(clr), .rd_off(idx),
        .rd_data(rd_data), .rd_loaded(rd_loaded), .mask(buf_mask)
    );

    // byte qualification against the state
    assign acc_first = (state == PL_IDLE) && supply_ok && ev;
    assign acc_more  = (state == PL_LOAD) && ev && (ev_addr[ADDR_W-1:OFF_W] == page_q);
    assign reject    = (state == PL_LOAD) && ev && (ev_addr[ADDR_W-1:OFF_W] != page_q);
    assign accept    = acc_first || acc_more;
    assign clr       = (state == PL_SETTLE) && twc_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PL_WAIT_PWR;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            PL_WAIT_PWR: if (supply_ok && por_done) state_nx = PL_IDLE;
            PL_IDLE: begin
                if (!supply_ok)     state_nx = PL_WAIT_PWR;
                else if (acc_first) state_nx = PL_LOAD;
            end
            PL_LOAD:     if (!acc_more && blc_done) state_nx = PL_PROGRAM;
            PL_PROGRAM:  if (idx == LAST_OFF) state_nx = PL_SETTLE;
            PL_SETTLE:   if (twc_done) state_nx = PL_IDLE;
            default:     state_nx = PL_WAIT_PWR;
        endcase
    end

    // registered datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q    <= '0;
            idx       <= '0;
            last_addr <= '0;
            last_data <= '0;
            page_err  <= 1'b0;
        end else begin
            if (acc_first) begin
                page_q   <= ev_addr[ADDR_W-1:OFF_W];
                page_err <= 1'b0;
            end
            if (reject) page_err <= 1'b1;
            if (accept) begin
                last_addr <= ev_addr;
                last_data <= ev_data;
            end
            if (state == PL_PROGRAM) idx <= idx + OFF_W'(1);
            else                     idx <= '0;
        end
    end

    // outputs
    always_comb begin
        busy         = (state == PL_PROGRAM) || (state == PL_SETTLE);
        commit_valid = (state == PL_PROGRAM) && rd_loaded;
        commit_addr  = {page_q, idx};
        commit_data  = rd_data;
    end

    assert_commit_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> busy);

    assert_commit_same_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (commit_addr[ADDR_W-1:OFF_W] == last_addr[ADDR_W-1:OFF_W]));

    assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(last_addr) && $stable(last_data)));

    assert_perr_from_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_err) |-> ($past(state) == PL_LOAD));

    assert_mask_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (buf_mask == '0));

    assert_pwr_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PL_WAIT_PWR) |=> (state != PL_LOAD));
endmodule

// File: tb/page_load_ctrl_bench.sv
module page_load_ctrl_bench;
    localparam int GL  = 3;
    localparam int BLC = 40;
    localparam int TWC = 100;
    localparam int POR = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b0;
    logic        bus_ce_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_din = '0;
    logic        busy, page_err, commit_valid;
    logic [14:0] last_addr, commit_addr;
    logic [7:0]  last_data, commit_data;

    always #4 clk = ~clk;

    page_load_ctrl #(.GLITCH_CYC(GL), .BLC_CYC(BLC), .TWC_CYC(TWC), .POR_CYC(POR)) u_page_load_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_din(bus_din),
        .busy(busy), .page_err(page_err), .last_addr(last_addr), .last_data(last_data),
        .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_data(commit_data)
    );

    int nchk = 0, nfail = 0, windows = 0, run = 0;
    bit prev_busy = 0, finished = 0;
    logic [22:0] exp_q[$];
    logic [7:0]  m_data [64];
    logic [63:0] m_mask = '0;
    logic [8:0]  m_page = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // expected-model driver side
    task automatic m_acc(input logic [14:0] a, input logic [7:0] d);
        if (m_mask == '0) m_page = a[14:6];
        m_data[a[5:0]] = d;
        m_mask[a[5:0]] = 1'b1;
    endtask

    task automatic m_close();
        for (int i = 0; i < 64; i++)
            if (m_mask[i]) exp_q.push_back({m_page, 6'(i), m_data[i]});
        m_mask = '0;
    endtask

    task automatic cyc(input logic c, input logic w, input logic o,
                       input logic [14:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_ce_n = c; bus_we_n = w; bus_oe_n = o; bus_addr = a; bus_din = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_ce_n = 1'b1; bus_we_n = 1'b1; bus_oe_n = 1'b1;
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d, input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, a, d);
        idle(6);
    endtask

    task automatic wait_prog();
        wait (busy === 1'b1);
        wait (busy === 1'b0);
        idle(3);
    endtask

    // monitor: scoreboard and programming-period length
    always @(negedge clk) begin
        if (rst_n) begin
            if (commit_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected commit", {commit_addr, commit_data}, 0);
                end else begin
                    logic [22:0] it;
                    it = exp_q.pop_front();
                    check({commit_addr, commit_data} == it, "R6/R7", "commit {addr,data}",
                          {commit_addr, commit_data}, it);
                end
            end
            if (busy) run++;
            if (!busy && prev_busy) begin
                windows++;
                check(run == TWC, "R5", "busy length", run, TWC);
                run = 0;
            end
            prev_busy = busy;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R11 reset state
        check(busy == 0, "R11", "busy after reset", busy, 0);
        check(page_err == 0, "R11", "page_err after reset", page_err, 0);
        check(last_addr == 0 && last_data == 0, "R11", "last after reset", {last_addr, last_data}, 0);
        check(commit_valid == 0, "R11", "commit_valid after reset", commit_valid, 0);

        // R10: no supply, then inside the power-on wait
        wr(15'h0100, 8'hAA, 4);
        idle(6);
        check(last_addr == 0, "R10", "write without supply", last_addr, 0);
        supply_ok = 1'b1;
        idle(2);
        wr(15'h0101, 8'hBB, 4);
        idle(4);
        check(last_addr == 0, "R10", "write inside power-on wait", last_addr, 0);
        idle(30);

        // R2: write strobe first with junk, chip select late, data changes, chip select rises first
        cyc(1'b1, 1'b0, 1'b1, 15'h7777, 8'h00);
        cyc(1'b1, 1'b0, 1'b1, 15'h7777, 8'h00);
        cyc(1'b0, 1'b0, 1'b1, 15'h0485, 8'h11);
        cyc(1'b0, 1'b0, 1'b1, 15'h0485, 8'h11);
        cyc(1'b0, 1'b0, 1'b1, 15'h3333, 8'h5C);
        cyc(1'b0, 1'b0, 1'b1, 15'h3333, 8'h5C);
        cyc(1'b1, 1'b0, 1'b1, 15'h3333, 8'hEE);
        idle(8);
        m_acc(15'h0485, 8'h5C);
        m_close();
        check(last_addr == 15'h0485, "R2", "address at late falling edge", last_addr, 15'h0485);
        check(last_data == 8'h5C, "R2", "data at early rising edge", last_data, 8'h5C);
        wait_prog();

        // R4/R7: out-of-order bytes on the top page, offset 0 rewritten
        wr(15'h7FFF, 8'h3F, 4); m_acc(15'h7FFF, 8'h3F);
        wr(15'h7FC0, 8'h01, 4); m_acc(15'h7FC0, 8'h01);
        wr(15'h7FD1, 8'h71, 4); m_acc(15'h7FD1, 8'h71);
        wr(15'h7FC0, 8'hC3, 4); m_acc(15'h7FC0, 8'hC3);
        m_close();
        check(last_data == 8'hC3, "R7", "rewrite data", last_data, 8'hC3);
        wait_prog();

        // R1 boundary and R3 inhibits inside one window
        wr(15'h0040, 8'h11, GL); m_acc(15'h0040, 8'h11); m_close();
        wr(15'h0041, 8'h22, GL - 1);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 15'h0042, 8'h33);
        idle(6);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b1, 15'h0043, 8'h44);
        idle(6);
        check(last_addr == 15'h0040, "R1/R3", "glitch and inhibited writes dropped", last_addr, 15'h0040);
        wait_prog();

        // R8: foreign page during loading
        wr(15'h0083, 8'h77, 4); m_acc(15'h0083, 8'h77); m_close();
        wr(15'h00C4, 8'h88, 4);
        idle(2);
        check(page_err == 1, "R8", "page_err set", page_err, 1);
        check(last_addr == 15'h0083, "R8", "foreign byte dropped", last_addr, 15'h0083);
        wait_prog();

        // R8 clear and R9: write during busy
        wr(15'h0100, 8'h99, 4); m_acc(15'h0100, 8'h99); m_close();
        check(page_err == 0, "R8", "page_err cleared by new window", page_err, 0);
        wait (busy === 1'b1);
        idle(5);
        wr(15'h0105, 8'hEE, 4);
        idle(2);
        check(last_addr == 15'h0100, "R9", "write during busy dropped", last_addr, 15'h0100);
        wait (busy === 1'b0);
        idle(BLC + 20);
        check(busy == 0, "R9", "no window from busy write", busy, 0);

        // R12: mask cleared between windows
        wr(15'h0141, 8'h12, 4); m_acc(15'h0141, 8'h12); m_close();
        wait_prog();
        wr(15'h0142, 8'h34, 4); m_acc(15'h0142, 8'h34); m_close();
        wait_prog();

        // R4: spaced bytes inside the limit share a window
        wr(15'h0180, 8'hA0, 4); m_acc(15'h0180, 8'hA0);
        idle(20);
        check(busy == 0, "R4", "window still open", busy, 0);
        wr(15'h0181, 8'hA1, 4); m_acc(15'h0181, 8'hA1); m_close();
        wait_prog();

        // R10: supply drop while idle restarts the wait
        supply_ok = 1'b0;
        idle(3);
        supply_ok = 1'b1;
        idle(1);
        wr(15'h01C0, 8'h55, 4);
        idle(4);
        check(last_addr == 15'h0181, "R10", "write after supply drop", last_addr, 15'h0181);
        idle(BLC + 10);
        check(busy == 0, "R10", "no programming after supply drop", busy, 0);

        check(exp_q.size() == 0, "R6", "all expected commits seen", exp_q.size(), 0);
        check(windows == 8, "R5", "programming periods", windows, 8);
        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule